// File: doc/BRIEF.md
# Calibrated ADC code linearizer

This block turns a 10-bit raw code from a general-purpose ADC into a signed physical value, in millivolts or milliamps, for one of nine measurement classes. Four of the classes can be trimmed by two-point factory calibration. The calibration codes are packed into ten one-time-programmable bytes. Those bytes arrive on a parallel load port, each with its own valid flag. When a load pulse arrives, the block latches the codes. A single shared serial divider then derives a gain and an offset for each trimmable class. The block raises a ready flag once every coefficient is in place.

After ready is raised, each accepted request yields one registered result on the next cycle. A trimmable class that has usable calibration is converted with its gain and offset. Any other class uses a nominal straight-line mapping from its minimum to its maximum. An unknown class selector produces an error pulse and no result.

Top module: `adc_code_linearizer`

## Requirements
- R1: After reset, cal_ready, out_valid and out_err are low. Before the first OTP load completes, a request produces neither out_valid nor out_err.
- R2: Class encoding and nominal ranges. 0 main charger voltage 0..20030, 1 battery temperature 0..1350, 2 battery voltage 2300..4800, 3 battery current -6000..6000, 4 charger current 0..1500, 5 backup battery 0..3200, 6 die temperature 0..1350, 7 second accessory detect 0..2500, 8 bus voltage 0..20030. An uncalibrated result is min + floor((max-min)*code/1024).
- R3: Byte k of the OTP data sits at otp_bytes[8k+7:8k], and its valid flag is otp_ok[k]. The codes are unpacked as follows, with the most significant part listed first. Main high = b0[1:0],b1[5:0],b2[7:6]; main low = b2[5:1]. Temperature high = b2[0],b3,b4[7]; temperature low = b4[6:2]. Battery high = b4[1:0],b5; battery low = b6[7:2]. Current high = b7[2:0],b8[7:1]; current low = b8[0],b9[7:3].
- R4: The calibration points are main 19500/315 mV, temperature 1300/21 mV and battery 4700/2380 mV. For these classes, gain = trunc(1000*(Vhigh-Vlow)/(high-low)) and offset = 1000*Vhigh - gain*high. The result is (code*gain+offset)/1000, truncated toward zero.
- R5: For the current class, g = trunc((112*2^20)/(high-low)) and o = 56*2^20 - g*high. The result is floor((code*g*100 + o*100) / 2^20), which maps ±56 mV onto ±5600 mA at 100 mA per mV.
- R6: A trimmable class falls back to its nominal mapping in two cases: any of its bytes lacks a valid flag, or its high code is not greater than its low code. The bytes are b0-b2 for main, b2-b4 for temperature, b4-b6 for battery and b7-b9 for current.
- R7: Classes 4 to 8 always use the nominal mapping, whatever the calibration.
- R8: A request with class 9..15 while ready gives a one-cycle out_err pulse on the next cycle, with out_valid low. out_valid and out_err are never high together.
- R9: An otp_load pulse clears cal_ready on the next cycle. cal_ready rises exactly 4*(DIV_W+1) cycles after the cycle in which the load is sampled, and requests made while it is low are dropped.
- R10: A request accepted while ready gives out_valid and out_value in the next cycle only. out_valid lasts one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| otp_load | input | 1 | Single-cycle pulse that latches the OTP bytes and starts coefficient computation |
| otp_bytes | input | 80 | Ten calibration bytes, byte k at bits 8k+7:8k |
| otp_ok | input | 10 | Per-byte read-success flags |
| in_valid | input | 1 | Conversion request |
| in_code | input | 10 | Raw ADC code |
| in_class | input | 4 | Measurement class selector |
| cal_ready | output | 1 | Coefficients are valid and requests are accepted |
| out_valid | output | 1 | Result valid pulse |
| out_err | output | 1 | Unknown-class pulse |
| out_value | output | 32 | Signed result in mV or mA |

## Verification
The checker assumes that otp_load is a single-cycle pulse. It also assumes that the class selector is stable for the cycle in which in_valid is sampled, since the range check on class 4 looks back one cycle at the selector. The bench drives every input on the falling edge and holds each for exactly one cycle. It pulses otp_load alone, and it sends requests only from a task that drops in_valid after one cycle. As a result, each result is traced to a single request. The calibration values chosen include a negative voltage offset, a current result below zero, and an inverted code pair, so the truncation and fallback corners are all reached.

// File: rtl/adc_code_linearizer.sv
`timescale 1ns/1ps
module adc_code_linearizer #(
  parameter int CODE_W = 10,
  parameter int OUT_W  = 32,
  parameter int DIV_W  = 27,
  parameter int ACC_W  = 64,
  parameter int FRAC   = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    otp_load,
  input  logic [79:0]             otp_bytes,
  input  logic [9:0]              otp_ok,
  input  logic                    in_valid,
  input  logic [CODE_W-1:0]       in_code,
  input  logic [3:0]              in_class,
  output logic                    cal_ready,
  output logic                    out_valid,
  output logic                    out_err,
  output logic signed [OUT_W-1:0] out_value
);
  localparam int STEP_W = $clog2(DIV_W);
  localparam logic signed [ACC_W-1:0] SCALE   = ACC_W'(1000);
  localparam logic signed [ACC_W-1:0] MA_MV   = ACC_W'(100);
  localparam logic signed [ACC_W-1:0] DROP_SH = ACC_W'(56) << FRAC;

  logic [CODE_W-1:0] hi_q [4];
  logic [CODE_W-1:0] lo_q [4];
  logic [3:0]        rok_q;
  logic signed [ACC_W-1:0] gain [4];
  logic signed [ACC_W-1:0] offs [4];

  logic              busy, load;
  logic [1:0]        slot;
  logic [STEP_W-1:0] step;
  logic [DIV_W-1:0]  num_sh, quo, numer;
  logic [CODE_W:0]   rem, den, rem_try, rem_nx;
  logic              ge, slot_ok;
  logic [DIV_W-1:0]  quo_nx;
  logic signed [ACC_W-1:0] g_new, hi_s, vhi;

  assign slot_ok = rok_q[slot] && (hi_q[slot] > lo_q[slot]);
  assign den     = slot_ok ? ({1'b0, hi_q[slot]} - {1'b0, lo_q[slot]}) : (CODE_W+1)'(1);
  assign rem_try = {rem[CODE_W-1:0], num_sh[DIV_W-1]};
  assign ge      = rem_try >= den;
  assign rem_nx  = ge ? rem_try - den : rem_try;
  assign quo_nx  = {quo[DIV_W-2:0], ge};
  assign g_new   = signed'({{(ACC_W-DIV_W){1'b0}}, quo_nx});
  assign hi_s    = signed'({{(ACC_W-CODE_W){1'b0}}, hi_q[slot]});

  always_comb begin
    case (slot)
      2'd0:    begin numer = DIV_W'(19185000);  vhi = ACC_W'(19500); end
      2'd1:    begin numer = DIV_W'(1279000);   vhi = ACC_W'(1300);  end
      2'd2:    begin numer = DIV_W'(2320000);   vhi = ACC_W'(4700);  end
      default: begin numer = DIV_W'(112 << FRAC); vhi = '0;          end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; load <= 1'b0; slot <= '0; step <= '0;
      num_sh <= '0; quo <= '0; rem <= '0; rok_q <= '0; cal_ready <= 1'b0;
      for (int k = 0; k < 4; k++) begin
        hi_q[k] <= '0; lo_q[k] <= '0; gain[k] <= '0; offs[k] <= '0;
      end
    end else if (otp_load) begin
      hi_q[0] <= {otp_bytes[1:0], otp_bytes[13:8], otp_bytes[23:22]};
      lo_q[0] <= CODE_W'(otp_bytes[21:17]);
      hi_q[1] <= {otp_bytes[16], otp_bytes[31:24], otp_bytes[39]};
      lo_q[1] <= CODE_W'(otp_bytes[38:34]);
      hi_q[2] <= {otp_bytes[33:32], otp_bytes[47:40]};
      lo_q[2] <= CODE_W'(otp_bytes[55:50]);
      hi_q[3] <= {otp_bytes[58:56], otp_bytes[71:65]};
      lo_q[3] <= CODE_W'({otp_bytes[64], otp_bytes[79:75]});
      rok_q   <= {&otp_ok[9:7], &otp_ok[6:4], &otp_ok[4:2], &otp_ok[2:0]};
      busy <= 1'b1; load <= 1'b1; slot <= '0; cal_ready <= 1'b0;
    end else if (busy && load) begin
      num_sh <= numer; rem <= '0; quo <= '0; step <= '0; load <= 1'b0;
    end else if (busy) begin
      num_sh <= num_sh << 1;
      rem    <= rem_nx;
      quo    <= quo_nx;
      step   <= step + 1'b1;
      if (step == STEP_W'(DIV_W-1)) begin
        if (!slot_ok) begin
          gain[slot] <= '0; offs[slot] <= '0;
        end else if (slot == 2'd3) begin
          gain[slot] <= g_new * MA_MV;
          offs[slot] <= (DROP_SH - g_new * hi_s) * MA_MV;
        end else begin
          gain[slot] <= g_new;
          offs[slot] <= SCALE * vhi - g_new * hi_s;
        end
        if (slot == 2'd3) begin
          busy <= 1'b0; cal_ready <= 1'b1;
        end else begin
          slot <= slot + 1'b1; load <= 1'b1;
        end
      end
    end
  end

  logic signed [ACC_W-1:0] nmin, nspan, code_s, cal_acc, res;
  logic known, use_cal;

  assign code_s  = signed'({{(ACC_W-CODE_W){1'b0}}, in_code});
  assign use_cal = (in_class < 4'd4) && (gain[in_class[1:0]] != '0);
  assign cal_acc = code_s * gain[in_class[1:0]] + offs[in_class[1:0]];

  always_comb begin
    known = 1'b1;
    case (in_class)
      4'd0:    begin nmin = '0;             nspan = ACC_W'(20030); end
      4'd1:    begin nmin = '0;             nspan = ACC_W'(1350);  end
      4'd2:    begin nmin = ACC_W'(2300);   nspan = ACC_W'(2500);  end
      4'd3:    begin nmin = -ACC_W'(6000);  nspan = ACC_W'(12000); end
      4'd4:    begin nmin = '0;             nspan = ACC_W'(1500);  end
      4'd5:    begin nmin = '0;             nspan = ACC_W'(3200);  end
      4'd6:    begin nmin = '0;             nspan = ACC_W'(1350);  end
      4'd7:    begin nmin = '0;             nspan = ACC_W'(2500);  end
      4'd8:    begin nmin = '0;             nspan = ACC_W'(20030); end
      default: begin nmin = '0;             nspan = '0; known = 1'b0; end
    endcase
    if (use_cal)
      res = (in_class == 4'd3) ? (cal_acc >>> FRAC) : (cal_acc / SCALE);
    else
      res = nmin + ((nspan * code_s) >>> CODE_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_err <= 1'b0; out_value <= '0;
    end else begin
      out_valid <= in_valid && cal_ready && known;
      out_err   <= in_valid && cal_ready && !known;
      if (in_valid && cal_ready)
        out_value <= known ? res[OUT_W-1:0] : '0;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{otp_bytes[7:2], otp_bytes[15:14], otp_bytes[49:48],
                         otp_bytes[63:59], otp_bytes[74:72], rem[CODE_W], res[ACC_W-1:OUT_W]};
endmodule

// File: rtl/adc_code_linearizer_chk.sv
`timescale 1ns/1ps
module adc_code_linearizer_chk #(
  parameter int OUT_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    otp_load,
  input logic                    in_valid,
  input logic [3:0]              in_class,
  input logic                    cal_ready,
  input logic                    out_valid,
  input logic                    out_err,
  input logic signed [OUT_W-1:0] out_value
);
  assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !cal_ready |=> !out_valid && !out_err);
  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    otp_load |=> !cal_ready);
  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_err));
  assert_unknown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cal_ready && in_class > 4'd8 |=> out_err);
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cal_ready && in_class <= 4'd8 |=> out_valid);
  assert_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  assert_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(in_class) == 4'd4 |-> out_value >= 0 && out_value <= 1500);
endmodule

bind adc_code_linearizer adc_code_linearizer_chk #(.OUT_W(OUT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .otp_load(otp_load), .in_valid(in_valid),
  .in_class(in_class), .cal_ready(cal_ready), .out_valid(out_valid),
  .out_err(out_err), .out_value(out_value)
);

// File: tb/test_adc_code_linearizer.sv
`timescale 1ns/1ps
module test_adc_code_linearizer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic otp_load = 1'b0, in_valid = 1'b0;
  logic [79:0] otp_bytes = '0;
  logic [9:0] otp_ok = '0;
  logic [9:0] in_code = '0;
  logic [3:0] in_class = '0;
  logic cal_ready, out_valid, out_err;
  logic signed [31:0] out_value;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  adc_code_linearizer i_adc_code_linearizer (
    .clk(clk), .rst_n(rst_n), .otp_load(otp_load), .otp_bytes(otp_bytes),
    .otp_ok(otp_ok), .in_valid(in_valid), .in_code(in_code), .in_class(in_class),
    .cal_ready(cal_ready), .out_valid(out_valid), .out_err(out_err), .out_value(out_value));

  typedef struct packed { logic [3:0] cls; logic [9:0] code; int expv; } vec_t;
  localparam vec_t NOM [13] = '{
    '{4'd0, 10'd512, 10015}, '{4'd0, 10'd1023, 20010}, '{4'd1, 10'd1000, 1318},
    '{4'd2, 10'd0, 2300},    '{4'd2, 10'd1023, 4797},  '{4'd3, 10'd0, -6000},
    '{4'd3, 10'd512, 0},     '{4'd3, 10'd100, -4829},  '{4'd4, 10'd300, 439},
    '{4'd5, 10'd1023, 3196}, '{4'd6, 10'd256, 337},    '{4'd7, 10'd700, 1708},
    '{4'd8, 10'd64, 1251}};

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic convert(input logic [3:0] cls, input logic [9:0] code,
                         output logic v, output logic e, output logic signed [31:0] val);
    @(negedge clk);
    in_class = cls; in_code = code; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    v = out_valid; e = out_err; val = out_value;
  endtask

  task automatic expect_val(input string req, input logic [3:0] cls, input logic [9:0] code,
                            input longint expv);
    logic v, e; logic signed [31:0] val;
    convert(cls, code, v, e, val);
    check(v && !e && longint'(val) == expv, req, longint'(val), expv);
  endtask

  function automatic logic [79:0] pack(int mh, int ml, int th, int tl, int bh, int bl, int ih, int il);
    logic [9:0] a = 10'(mh), c = 10'(th), d = 10'(bh), f = 10'(ih);
    logic [4:0] b = 5'(ml), t = 5'(tl);
    logic [5:0] g = 6'(bl), h = 6'(il);
    return {h[4:0], 3'b0, f[6:0], h[5], 5'b0, f[9:7], g, 2'b0, d[7:0],
            c[0], t, d[9:8], c[8:1], a[1:0], b, c[9], 2'b0, a[7:2], 6'b0, a[9:8]};
  endfunction

  function automatic longint volt_model(longint hi, longint lo, longint vh, longint vl, longint code);
    longint g = (1000 * (vh - vl)) / (hi - lo);
    longint o = 1000 * vh - g * hi;
    return (code * g + o) / 1000;
  endfunction

  function automatic longint cur_model(longint hi, longint lo, longint code);
    longint g = (longint'(112) <<< 20) / (hi - lo);
    longint o = (longint'(56) <<< 20) - g * hi;
    return (code * g * 100 + o * 100) >>> 20;
  endfunction

  task automatic load(input logic [79:0] bytes, input logic [9:0] ok, output int cycles);
    @(negedge clk);
    otp_bytes = bytes; otp_ok = ok; otp_load = 1'b1;
    @(negedge clk);
    otp_load = 1'b0;
    cycles = 0;
    while (!cal_ready && cycles < 1000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic v, e; logic signed [31:0] val; int cyc;
    repeat (3) @(negedge clk);
    check(!cal_ready && !out_valid && !out_err, "R1 reset outputs", cal_ready, 0);
    rst_n = 1'b1;
    convert(4'd2, 10'd100, v, e, val);
    check(!v && !e, "R1 request before load", v, 0);

    load('0, 10'h000, cyc);
    check(cyc == 112, "R9 ready latency", cyc, 112);
    for (int i = 0; i < 13; i++)
      expect_val("R2 nominal table", NOM[i].cls, NOM[i].code, NOM[i].expv);

    // R10: single-cycle pulse
    convert(4'd4, 10'd300, v, e, val);
    @(negedge clk);
    check(!out_valid, "R10 pulse width", out_valid, 0);

    // R8: unknown classes
    convert(4'd9, 10'd5, v, e, val);
    check(e && !v, "R8 class 9", e, 1);
    convert(4'd15, 10'd5, v, e, val);
    check(e && !v, "R8 class 15", e, 1);

    // R9: requests dropped while busy
    @(negedge clk);
    otp_bytes = pack(997, 16, 985, 31, 982, 33, 900, 40); otp_ok = 10'h3FF; otp_load = 1'b1;
    @(negedge clk);
    otp_load = 1'b0;
    check(!cal_ready, "R9 ready cleared", cal_ready, 0);
    convert(4'd0, 10'd500, v, e, val);
    check(!v && !e, "R9 dropped while busy", v, 0);
    cyc = 0;
    while (!cal_ready && cyc < 1000) begin @(negedge clk); cyc++; end

    // R3 R4 calibrated voltage classes
    expect_val("R4 main low point", 4'd0, 10'd16, volt_model(997, 16, 19500, 315, 16));
    expect_val("R4 main mid", 4'd0, 10'd500, volt_model(997, 16, 19500, 315, 500));
    expect_val("R3 main high point", 4'd0, 10'd997, volt_model(997, 16, 19500, 315, 997));
    expect_val("R4 temp negative trunc", 4'd1, 10'd0, volt_model(985, 31, 1300, 21, 0));
    expect_val("R4 temp small code", 4'd1, 10'd14, volt_model(985, 31, 1300, 21, 14));
    expect_val("R3 temp high", 4'd1, 10'd985, volt_model(985, 31, 1300, 21, 985));
    expect_val("R3 vbat zero", 4'd2, 10'd0, volt_model(982, 33, 4700, 2380, 0));
    expect_val("R4 vbat mid", 4'd2, 10'd600, volt_model(982, 33, 4700, 2380, 600));
    // R5 current class
    expect_val("R5 current zero", 4'd3, 10'd0, cur_model(900, 40, 0));
    expect_val("R5 current low", 4'd3, 10'd40, cur_model(900, 40, 40));
    expect_val("R5 current high", 4'd3, 10'd900, cur_model(900, 40, 900));
    expect_val("R5 current mid", 4'd3, 10'd512, cur_model(900, 40, 512));
    // R7 uncalibrated classes unchanged
    expect_val("R7 bus voltage", 4'd8, 10'd64, 1251);
    expect_val("R7 charger current", 4'd4, 10'd300, 439);
    expect_val("R7 die temp", 4'd6, 10'd256, 337);

    // R6: byte 4 missing -> temp and vbat nominal
    load(pack(997, 16, 985, 31, 982, 33, 900, 40), 10'b11_1110_1111, cyc);
    expect_val("R6 temp fallback", 4'd1, 10'd1000, 1318);
    expect_val("R6 vbat fallback", 4'd2, 10'd1023, 4797);
    expect_val("R6 main still cal", 4'd0, 10'd500, volt_model(997, 16, 19500, 315, 500));
    expect_val("R6 current still cal", 4'd3, 10'd512, cur_model(900, 40, 512));
    // R6: inverted main codes -> nominal
    load(pack(10, 20, 985, 31, 982, 33, 900, 40), 10'h3FF, cyc);
    expect_val("R6 main inverted", 4'd0, 10'd512, 10015);
    expect_val("R6 temp cal", 4'd1, 10'd14, volt_model(985, 31, 1300, 21, 14));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule